// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one accepted read or write command into the run of column addresses that the burst walks through, one address per clock. A small mode register, loaded by a strobe, holds the burst length code, the ordering (sequential or interleaved) and a single-write option. Each command carries a start column and a read/write flag. From the next cycle on, the block presents one column per cycle with a beat-valid strobe and flags the final beat of a fixed-length burst.

Fixed-length bursts stay inside an aligned block whose size is the burst length. Full-page bursts step through the whole 512-column row, wrap from the top column back to zero, and keep going until a stop request arrives. A new command at any time cuts off the burst in progress. The stop input ends a burst. The controller drives it both for an explicit burst stop and when it closes the row. Array access, data timing and latency alignment belong to neighbouring logic.

The control is a three-state machine. `ST_IDLE` produces no beats. `ST_FIXED` runs a burst of 1, 2, 4 or 8 beats. `ST_PAGE` runs an open-ended full-page burst. The transitions are:
- start-fixed: any state to `ST_FIXED`, on a command under a fixed length.
- start-page: any state to `ST_PAGE`, on a command under full page.
- finish: `ST_FIXED` to `ST_IDLE`, after the final beat.
- stop: `ST_FIXED` or `ST_PAGE` to `ST_IDLE`, on the stop input.
- restart: a command that arrives while a burst is running reloads the machine.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset no beat is valid, and the mode register holds length code 000 (one beat), sequential order and single-write off.
- R2: When a command is accepted on a clock edge, the next cycle shows beat_valid high with col_out equal to the command's start column.
- R3: Mode bits [2:0] select the length: 000=1, 001=2, 010=4, 011=8 beats. A fixed burst gives exactly that many consecutive valid beats. beat_last is high on the final beat only, and the cycle after it is idle unless a new command arrives.
- R4: With mode bit 3 = 0 (sequential), beat k of a fixed burst of length L has col_out low bits = (start + k) mod L. The column bits above the block stay equal to the start column's.
- R5: With mode bit 3 = 1 (interleaved), beat k of a fixed burst has col_out low bits = start XOR k within the block of length L. The upper bits are unchanged.
- R6: Length code 111 is a full-page burst. Columns step by +1 modulo 512, whatever the order bit says, and beat_last stays low throughout. The burst runs until stopped.
- R7: With mode bit 4 = 1, every write is a single beat. Reads keep the programmed length. This does not apply to full-page bursts, which ignore the bit.
- R8: burst_stop high on an edge, without cmd_start, makes the following cycle idle.
- R9: A command accepted during a running burst cuts it off. The new burst's first beat appears on the next cycle, and it wins over a same-cycle burst_stop.
- R10: burst_stop while idle has no effect. A mode load takes effect only for commands accepted on later edges; a running burst and a same-edge command use the earlier mode.
- R11: The unused length codes 100, 101 and 110 behave as a one-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Loads mode_word into the mode register |
| mode_word | input | 5 | [2:0] length code, [3] order (1=interleaved), [4] single-write |
| cmd_start | input | 1 | Accept a read/write command this edge |
| cmd_col | input | COL_W (9) | Start column of the command |
| cmd_is_write | input | 1 | 1 = write command, 0 = read |
| burst_stop | input | 1 | Ends the burst in progress |
| col_out | output | COL_W (9) | Column for the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Final beat of a fixed-length burst |

## Verification
On every cycle, the assertions check several timing rules. The first beat must follow an accepted command and carry its column. A stop, or a final beat, must leave the next cycle idle. An idle cycle without a command must stay idle. Within a fixed burst the bits above the block must stay constant, and a full page must step by one and never raise the last flag. Only the bench's scenarios can show the following: the exact sequential and interleaved order within a block, the burst length chosen by each code, the single-write rule for writes against reads, the unused codes, and the timing of a mode load relative to a running burst or a same-edge command.

// File: rtl/sbcg_pkg.sv
package sbcg_pkg;

    localparam int LEN_FIELD_W  = 3;
    localparam int ORDER_BIT    = 3;
    localparam int WSINGLE_BIT  = 4;
    localparam int MODE_W       = 5;

    localparam logic [LEN_FIELD_W-1:0] LEN_CODE_1    = 3'b000;
    localparam logic [LEN_FIELD_W-1:0] LEN_CODE_2    = 3'b001;
    localparam logic [LEN_FIELD_W-1:0] LEN_CODE_4    = 3'b010;
    localparam logic [LEN_FIELD_W-1:0] LEN_CODE_8    = 3'b011;
    localparam logic [LEN_FIELD_W-1:0] LEN_CODE_PAGE = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } burst_state_t;

    typedef struct packed {
        logic [LEN_FIELD_W-1:0] len_code;
        logic                   interleave;
        logic                   write_single;
    } mode_fields_t;

endpackage

// File: rtl/sbcg_mode_reg.sv
module sbcg_mode_reg
    import sbcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    output mode_fields_t      mode
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode.len_code     <= LEN_CODE_1;
            mode.interleave   <= 1'b0;
            mode.write_single <= 1'b0;
        end else if (mode_load) begin
            mode.len_code     <= mode_word[LEN_FIELD_W-1:0];
            mode.interleave   <= mode_word[ORDER_BIT];
            mode.write_single <= mode_word[WSINGLE_BIT];
        end
    end

endmodule

// File: rtl/sbcg_burst_fsm.sv
module sbcg_burst_fsm
    import sbcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_is_write,
    input  logic             burst_stop,
    input  mode_fields_t     mode,
    output logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] beat_cnt,
    output logic [COL_W-1:0] burst_mask,
    output logic             burst_ilv,
    output logic             beat_valid,
    output logic             beat_last
);

    burst_state_t state, state_nxt;
    logic             start_page;
    logic [COL_W-1:0] fixed_mask;
    logic [COL_W-1:0] start_mask;
    logic             at_end;

    // length code -> in-block mask; unused codes fall back to one beat
    always_comb begin
        unique case (mode.len_code)
            LEN_CODE_2: fixed_mask = COL_W'(1);
            LEN_CODE_4: fixed_mask = COL_W'(3);
            LEN_CODE_8: fixed_mask = COL_W'(7);
            default:    fixed_mask = '0;
        endcase
    end

    assign start_page = (mode.len_code == LEN_CODE_PAGE);

    always_comb begin
        if (start_page)
            start_mask = '1;
        else if (cmd_is_write && mode.write_single)
            start_mask = '0;
        else
            start_mask = fixed_mask;
    end

    assign at_end = (beat_cnt == burst_mask);

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  state_nxt = ST_IDLE;
            ST_FIXED: state_nxt = (burst_stop || at_end) ? ST_IDLE : ST_FIXED;
            ST_PAGE:  state_nxt = burst_stop ? ST_IDLE : ST_PAGE;
            default:  state_nxt = ST_IDLE;
        endcase
        if (cmd_start)
            state_nxt = start_page ? ST_PAGE : ST_FIXED;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // burst context: captured on a command, counter advances per beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_col  <= '0;
            beat_cnt   <= '0;
            burst_mask <= '0;
            burst_ilv  <= 1'b0;
        end else if (cmd_start) begin
            start_col  <= cmd_col;
            beat_cnt   <= '0;
            burst_mask <= start_mask;
            burst_ilv  <= mode.interleave && !start_page;
        end else if (state != ST_IDLE) begin
            beat_cnt   <= beat_cnt + COL_W'(1);
        end
    end

    // outputs
    always_comb begin
        beat_valid = 1'b0;
        beat_last  = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_FIXED: begin
                beat_valid = 1'b1;
                beat_last  = at_end;
            end
            ST_PAGE:  beat_valid = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/sbcg_col_calc.sv
module sbcg_col_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat_cnt,
    input  logic [COL_W-1:0] burst_mask,
    input  logic             burst_ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_sum;

    assign seq_sum = start_col + beat_cnt;

    // bits inside the block follow the order; bits above it keep the start
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!burst_mask[b])
                col[b] = start_col[b];
            else if (burst_ilv)
                col[b] = start_col[b] ^ beat_cnt[b];
            else
                col[b] = seq_sum[b];
        end
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sbcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_start,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_is_write,
    input  logic              burst_stop,
    output logic [COL_W-1:0]  col_out,
    output logic              beat_valid,
    output logic              beat_last
);

    mode_fields_t     mode;
    logic [COL_W-1:0] start_col;
    logic [COL_W-1:0] beat_cnt;
    logic [COL_W-1:0] burst_mask;
    logic             burst_ilv;

    sbcg_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_load (mode_load),
        .mode_word (mode_word),
        .mode      (mode)
    );

    sbcg_burst_fsm #(.COL_W(COL_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .cmd_col      (cmd_col),
        .cmd_is_write (cmd_is_write),
        .burst_stop   (burst_stop),
        .mode         (mode),
        .start_col    (start_col),
        .beat_cnt     (beat_cnt),
        .burst_mask   (burst_mask),
        .burst_ilv    (burst_ilv),
        .beat_valid   (beat_valid),
        .beat_last    (beat_last)
    );

    sbcg_col_calc #(.COL_W(COL_W)) u_calc (
        .start_col  (start_col),
        .beat_cnt   (beat_cnt),
        .burst_mask (burst_mask),
        .burst_ilv  (burst_ilv),
        .col        (col_out)
    );

endmodule

// File: rtl/sbcg_checker.sv
module sbcg_checker #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic [COL_W-1:0] cmd_col,
    input logic             burst_stop,
    input logic [COL_W-1:0] col_out,
    input logic             beat_valid,
    input logic             beat_last,
    input logic [COL_W-1:0] burst_mask
);

    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> beat_valid && (col_out == $past(cmd_col)));

    p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !cmd_start) |=> !beat_valid);

    p_last_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    p_block_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last && !cmd_start && !burst_stop)
        |=> beat_valid && ((col_out & ~burst_mask) == ($past(col_out) & ~$past(burst_mask))));

    p_page_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && (burst_mask == '1)) |-> !beat_last);

    p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && (burst_mask == '1) && !cmd_start && !burst_stop)
        |=> beat_valid && (col_out == COL_W'($past(col_out) + COL_W'(1))));

    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !cmd_start) |=> !beat_valid);

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && !cmd_start) |=> !beat_valid);

endmodule

bind sdram_burst_colgen sbcg_checker #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_col    (cmd_col),
    .burst_stop (burst_stop),
    .col_out    (col_out),
    .beat_valid (beat_valid),
    .beat_last  (beat_last),
    .burst_mask (burst_mask)
);

// File: tb/sdram_burst_colgen_test.sv
`timescale 1ns/1ps
module sdram_burst_colgen_test;

    localparam int COL_W = 9;
    localparam int NCOL  = 512;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_load = 1'b0;
    logic [4:0]       mode_word = '0;
    logic             cmd_start = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cmd_is_write = 1'b0;
    logic             burst_stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             beat_valid;
    logic             beat_last;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model state
    int m_code = 0;
    bit m_ilv = 0, m_ws = 0;
    bit m_act = 0, m_page = 0, m_bilv = 0;
    int m_start = 0, m_mask = 0, m_cnt = 0;

    always #2 clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .cmd_start(cmd_start), .cmd_col(cmd_col), .cmd_is_write(cmd_is_write),
        .burst_stop(burst_stop), .col_out(col_out), .beat_valid(beat_valid),
        .beat_last(beat_last)
    );

    function automatic int len_mask(int code);
        case (code)
            1: return 1;
            2: return 3;
            3: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_col(int s, int c, int mk, bit il);
        int lo;
        lo = il ? (s ^ c) : (s + c);
        return ((s & ~mk) | (lo & mk)) & (NCOL - 1);
    endfunction

    function automatic int mw(int code, bit il, bit ws);
        return (code & 7) | (int'(il) << 3) | (int'(ws) << 4);
    endfunction

    task automatic check_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        bit ev, el;
        int ec;
        ev = m_act;
        el = m_act && !m_page && (m_cnt == m_mask);
        ec = exp_col(m_start, m_cnt, m_mask, m_bilv);
        checks++;
        if (beat_valid !== ev || beat_last !== el || (ev && int'(col_out) != ec)) begin
            failures++;
            $display("FAIL %s actual v=%0b l=%0b col=%0d expected v=%0b l=%0b col=%0d",
                     tag, beat_valid, beat_last, col_out, ev, el, ec);
        end
    endtask

    // drive one edge's inputs, advance the model, sample away from the edge
    task automatic step(bit st, int col, bit wr, bit stop, bit ml, int mwd, string tag);
        cmd_start = st; cmd_col = COL_W'(col); cmd_is_write = wr;
        burst_stop = stop; mode_load = ml; mode_word = 5'(mwd);
        @(posedge clk);
        if (st) begin
            m_act = 1; m_page = (m_code == 7); m_start = col & (NCOL - 1);
            m_mask = m_page ? NCOL - 1 : ((wr && m_ws) ? 0 : len_mask(m_code));
            m_bilv = m_page ? 0 : m_ilv; m_cnt = 0;
        end else if (m_act) begin
            if (stop || (!m_page && m_cnt == m_mask)) m_act = 0;
            else m_cnt = (m_cnt + 1) % NCOL;
        end
        if (ml) begin
            m_code = mwd & 7; m_ilv = mwd[3]; m_ws = mwd[4];
        end
        #1;
        compare(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic load(int code, bit il, bit ws, string tag);
        step(0, 0, 0, 0, 1, mw(code, il, ws), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c011));
        repeat (4) @(posedge clk);
        #1;
        check_val("R1 reset valid", int'(beat_valid), 0);
        check_val("R1 reset last", int'(beat_last), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: default mode gives a one-beat read
        step(1, 9'h03A, 0, 0, 0, 0, "R1");
        check_val("R1 default col", int'(col_out), 9'h03A);
        check_val("R1 default last", int'(beat_last), 1);
        idle(2, "R1");

        // R2/R3/R4: each fixed length, sequential, unaligned start
        for (int code = 0; code < 4; code++) begin
            load(code, 0, 0, "R3");
            step(1, 9'h0D5, 0, 0, 0, 0, "R2");
            idle(9, "R3");
        end
        load(3, 0, 0, "R4");
        step(1, 9'h0D5, 0, 0, 0, 0, "R4");
        idle(2, "R4");
        check_val("R4 wrap col", int'(col_out), 9'h0D7);
        idle(1, "R4");
        check_val("R4 wrap to block base", int'(col_out), 9'h0D0);
        idle(6, "R4");

        // R5: interleaved length 8 and 4
        load(3, 1, 0, "R5");
        step(1, 9'h105, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, "R5");
        check_val("R5 ilv beat1", int'(col_out), 9'h104);
        step(0, 0, 0, 0, 0, 0, "R5");
        check_val("R5 ilv beat2", int'(col_out), 9'h107);
        idle(7, "R5");
        load(2, 1, 0, "R5");
        step(1, 9'h0AE, 1, 0, 0, 0, "R5");
        idle(5, "R5");

        // R6: full page wraps, order bit ignored, then stop (R8)
        load(7, 1, 1, "R6");
        step(1, 9'h1FE, 1, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, "R6");
        check_val("R6 page 511", int'(col_out), 9'h1FF);
        step(0, 0, 0, 0, 0, 0, "R6");
        check_val("R6 page wrap 0", int'(col_out), 0);
        check_val("R6 page last low", int'(beat_last), 0);
        idle(20, "R6");
        step(0, 0, 0, 1, 0, 0, "R8");
        check_val("R8 stopped", int'(beat_valid), 0);
        idle(2, "R8");

        // R7: single-write mode
        load(3, 0, 1, "R7");
        step(1, 9'h044, 1, 0, 0, 0, "R7");
        check_val("R7 write single last", int'(beat_last), 1);
        step(0, 0, 0, 0, 0, 0, "R7");
        check_val("R7 write ended", int'(beat_valid), 0);
        step(1, 9'h044, 0, 0, 0, 0, "R7");
        idle(9, "R7");

        // R9: new command cuts off, and wins over same-edge stop
        load(3, 0, 0, "R9");
        step(1, 9'h010, 0, 0, 0, 0, "R9");
        idle(2, "R9");
        step(1, 9'h123, 0, 1, 0, 0, "R9");
        check_val("R9 restart col", int'(col_out), 9'h123);
        idle(9, "R9");

        // R10: stop while idle, mode load during a burst and on the command edge
        step(0, 0, 0, 1, 0, 0, "R10");
        check_val("R10 idle stop", int'(beat_valid), 0);
        step(1, 9'h030, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 1, mw(0, 0, 0), "R10");
        idle(8, "R10");
        step(1, 9'h031, 0, 0, 1, mw(2, 0, 0), "R10");
        check_val("R10 same-edge uses old mode", int'(beat_last), 1);
        step(1, 9'h031, 0, 0, 0, 0, "R10");
        idle(5, "R10");

        // R11: unused length codes
        for (int code = 4; code < 7; code++) begin
            load(code, 0, 0, "R11");
            step(1, 9'h077, 0, 0, 0, 0, "R11");
            check_val("R11 single beat", int'(beat_last), 1);
            idle(2, "R11");
        end

        // constrained random mix
        for (int i = 0; i < 5000; i++) begin
            int codes[6] = '{0, 1, 2, 3, 7, 5};
            bit st, sp, ml;
            st = ($urandom % 5) == 0;
            sp = ($urandom % 9) == 0;
            ml = ($urandom % 17) == 0;
            step(st, int'($urandom % NCOL), 1'($urandom), sp, ml,
                 mw(codes[$urandom % 6], 1'($urandom), 1'($urandom)), "R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule